// File: doc/BRIEF.md
# Synchronous Serial Frame Receiver

This block turns a serial data line into words. An external shift clock paces the line. Both the shift clock and the data line are first brought into the system clock domain. The line is then read on one edge of the shift clock, chosen by a polarity input. A frame opens with a low start bit on a line that idles high. The data bits follow, least significant first, then an optional parity bit and one or two stop bits.

The data length (5 to 9 bits), the parity mode and the stop-bit count are runtime inputs. They must match the setting used by the transmitting side. At the end of each frame the block raises a one-cycle valid strobe. The strobe comes with the received word, a parity-error flag and a frame-error flag. If any format or polarity input changes while a frame is in flight, that frame is dropped and the block waits for a new start bit.

Top module: `sync_frame_rx`

## Requirements
- R1: With `cfg_pol_i` = 0 the line is read on falling edges of `sclk_i`. Rising edges do not read the line.
- R2: With `cfg_pol_i` = 1 the line is read on rising edges of `sclk_i`. Falling edges do not read the line.
- R3: While idle, a sampled high line starts nothing. A sampled low bit starts a frame. Clock edges on a high line produce no valid strobe.
- R4: Data bits fill `word_o` from bit 0 upward. `cfg_len_i` codes 0,1,2,3,4 select 5,6,7,8,9 data bits, and codes 5 to 7 also select 9 bits.
- R5: Bits of `word_o` at and above the data length read zero on a valid strobe.
- R6: With `cfg_par_i` = 2'b10 (even), `par_err_o` is set when the ones count over the data and parity bits is odd.
- R7: With `cfg_par_i` = 2'b11 (odd), `par_err_o` is set when the ones count over the data and parity bits is even.
- R8: With `cfg_par_i[1]` = 0, no parity bit is read, the first stop bit directly follows the data, and `par_err_o` stays low.
- R9: A low first stop bit sets `frm_err_o` together with the valid strobe, and the word is still delivered.
- R10: With `cfg_two_stop_i` = 1, the second stop bit is read but not checked. A low second stop bit neither flags an error nor starts a frame.
- R11: A change of any of `cfg_len_i`, `cfg_par_i`, `cfg_two_stop_i` or `cfg_pol_i` during a frame drops that frame with no valid strobe. The next start bit is received normally.
- R12: `valid_o` is a single-cycle pulse. The error flags are high only in the same cycle as `valid_o`. All three are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | External shift clock (asynchronous to clk) |
| line_i | input | 1 | Serial data line, idles high |
| cfg_pol_i | input | 1 | 0: read on falling edge, 1: read on rising edge |
| cfg_len_i | input | 3 | Data length code (0..4 gives 5..9 bits) |
| cfg_par_i | input | 2 | 0x: no parity, 10: even, 11: odd |
| cfg_two_stop_i | input | 1 | 1: two stop bits per frame |
| word_o | output | MAX_BITS | Received word, unused upper bits zero |
| valid_o | output | 1 | One-cycle strobe per completed frame |
| par_err_o | output | 1 | Parity mismatch, qualified by valid_o |
| frm_err_o | output | 1 | First stop bit low, qualified by valid_o |

## Verification
The bench builds the block with its defaults: a 9-bit word and a two-stage synchronizer. This lets every data length from 5 to 9 bits reach the output, including the top data bit in 9-bit mode. Each shift clock level is held for six system clocks. The bench moves the line two system clocks after the edge that does not read it. A receiver that reads on the wrong edge therefore picks up the previous bit, so the polarity checks can catch it.

// File: rtl/sfr_pkg.sv
// Package: shared types and helpers for the synchronous frame receiver.
// Assumes a maximum data length of nine bits.
package sfr_pkg;

    localparam int unsigned MAX_DATA_BITS = 9;

    typedef enum logic [2:0] {
        RX_IDLE  = 3'd0,
        RX_DATA  = 3'd1,
        RX_PAR   = 3'd2,
        RX_STOP  = 3'd3,
        RX_STOP2 = 3'd4
    } rx_state_e;

    // Maps the 3-bit length code to a data bit count, saturating at nine.
    function automatic int unsigned data_bits(input logic [2:0] code);
        if (code > 3'd4) return MAX_DATA_BITS;
        return int'(code) + 5;
    endfunction

endpackage

// File: rtl/sfr_sync.sv
// Module: multi-stage synchronizer for one asynchronous level.
// Assumes the input level is held for longer than STAGES system clocks.
module sfr_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Purpose: one flop of the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[g] <= RST_VAL;
                else if (g == 0) chain_q[g] <= d_i;
                else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sfr_edge.sv
// Module: finds the sampling edge of a synchronized shift clock.
// Polarity 0 selects falling edges and polarity 1 selects rising edges.
module sfr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic pol_i,
    output logic sample_o
);
    logic prev_q;

    // Purpose: remember the previous clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= lvl_i;
    end

    // Purpose: pick the edge that the polarity selects.
    always_comb begin
        if (pol_i) sample_o = lvl_i & ~prev_q;
        else       sample_o = ~lvl_i & prev_q;
    end
endmodule

// File: rtl/sfr_deser.sv
// Module: frame state machine and shift register.
// Acts on single-cycle sample pulses. Any change of the format inputs while
// a frame is open drops the frame.
module sfr_deser
    import sfr_pkg::*;
#(
    parameter int unsigned MAX_BITS = MAX_DATA_BITS,
    localparam int unsigned CNT_W   = $clog2(MAX_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_i,
    input  logic                bit_i,
    input  logic                pol_i,
    input  logic [2:0]          len_i,
    input  logic [1:0]          par_i,
    input  logic                two_stop_i,
    output logic [MAX_BITS-1:0] word_o,
    output logic                valid_o,
    output logic                par_err_o,
    output logic                frm_err_o
);
    rx_state_e           state_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [MAX_BITS-1:0] shreg_q;
    logic                acc_q;
    logic [6:0]          cfg_q;
    logic [6:0]          cfg_now;
    logic                cfg_chg;
    logic [CNT_W-1:0]    last_idx;

    assign cfg_now  = {pol_i, len_i, par_i, two_stop_i};
    assign cfg_chg  = (cfg_now != cfg_q);
    assign last_idx = CNT_W'(data_bits(len_i) - 1);

    // Purpose: frame sequencing, bit capture and result strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= RX_IDLE;
            cnt_q     <= '0;
            shreg_q   <= '0;
            acc_q     <= 1'b0;
            cfg_q     <= cfg_now;
            word_o    <= '0;
            valid_o   <= 1'b0;
            par_err_o <= 1'b0;
            frm_err_o <= 1'b0;
        end else begin
            valid_o   <= 1'b0;
            par_err_o <= 1'b0;
            frm_err_o <= 1'b0;
            cfg_q     <= cfg_now;
            if (cfg_chg && state_q != RX_IDLE) begin
                state_q <= RX_IDLE;
            end else if (sample_i) begin
                case (state_q)
                    RX_IDLE: if (!bit_i) begin
                        state_q <= RX_DATA;
                        cnt_q   <= '0;
                        shreg_q <= '0;
                        acc_q   <= 1'b0;
                    end
                    RX_DATA: begin
                        shreg_q[cnt_q] <= bit_i;
                        acc_q          <= acc_q ^ bit_i;
                        if (cnt_q == last_idx)
                            state_q <= par_i[1] ? RX_PAR : RX_STOP;
                        else
                            cnt_q <= cnt_q + 1'b1;
                    end
                    RX_PAR: begin
                        acc_q   <= acc_q ^ bit_i;
                        state_q <= RX_STOP;
                    end
                    RX_STOP: begin
                        valid_o   <= 1'b1;
                        word_o    <= shreg_q;
                        par_err_o <= par_i[1] && (acc_q != par_i[0]);
                        frm_err_o <= ~bit_i;
                        state_q   <= two_stop_i ? RX_STOP2 : RX_IDLE;
                    end
                    RX_STOP2: state_q <= RX_IDLE;
                    default:  state_q <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/sync_frame_rx.sv
// Module: top of the synchronous serial frame receiver.
// Assumes each shift clock level lasts at least three system clocks, so that
// the synchronizer passes every edge.
module sync_frame_rx
    import sfr_pkg::*;
#(
    parameter int unsigned MAX_BITS    = MAX_DATA_BITS,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk_i,
    input  logic                line_i,
    input  logic                cfg_pol_i,
    input  logic [2:0]          cfg_len_i,
    input  logic [1:0]          cfg_par_i,
    input  logic                cfg_two_stop_i,
    output logic [MAX_BITS-1:0] word_o,
    output logic                valid_o,
    output logic                par_err_o,
    output logic                frm_err_o
);
    logic sclk_s, line_s, sample;

    sfr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_clk (
        .clk(clk), .rst_n(rst_n), .d_i(sclk_i), .q_o(sclk_s));

    sfr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_line (
        .clk(clk), .rst_n(rst_n), .d_i(line_i), .q_o(line_s));

    sfr_edge u_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(sclk_s), .pol_i(cfg_pol_i),
        .sample_o(sample));

    sfr_deser #(.MAX_BITS(MAX_BITS)) u_deser (
        .clk(clk), .rst_n(rst_n), .sample_i(sample), .bit_i(line_s),
        .pol_i(cfg_pol_i), .len_i(cfg_len_i), .par_i(cfg_par_i),
        .two_stop_i(cfg_two_stop_i), .word_o(word_o), .valid_o(valid_o),
        .par_err_o(par_err_o), .frm_err_o(frm_err_o));
endmodule

// File: rtl/sync_frame_rx_chk.sv
// Module: property checker attached to sync_frame_rx by a bind.
module sync_frame_rx_chk #(
    parameter int unsigned MAX_BITS = 9
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2:0]          cfg_len_i,
    input logic [1:0]          cfg_par_i,
    input logic [MAX_BITS-1:0] word_o,
    input logic                valid_o,
    input logic                par_err_o,
    input logic                frm_err_o
);
    // R12
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R12
    flag_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (par_err_o || frm_err_o) |-> valid_o);

    // R12
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && !par_err_o && !frm_err_o));

    // R5
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(cfg_len_i) == 3'd0 && $stable(cfg_len_i))
            |-> (word_o[MAX_BITS-1:5] == '0));

    // R8
    no_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !$past(cfg_par_i[1]) && $stable(cfg_par_i)) |-> !par_err_o);
endmodule

bind sync_frame_rx sync_frame_rx_chk #(.MAX_BITS(MAX_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_len_i(cfg_len_i), .cfg_par_i(cfg_par_i),
    .word_o(word_o), .valid_o(valid_o), .par_err_o(par_err_o),
    .frm_err_o(frm_err_o));

// File: tb/sync_frame_rx_tb.sv
module sync_frame_rx_tb;
    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       line = 1'b1;
    logic       pol = 1'b0;
    logic [2:0] len = 3'd3;
    logic [1:0] par = 2'b00;
    logic       two = 1'b0;
    logic [8:0] word;
    logic       valid, perr, ferr;

    int n_chk = 0, n_fail = 0, n_val = 0, n_dbl = 0;
    logic [8:0] l_word;
    logic l_perr, l_ferr, prev_valid = 1'b0;

    always #2 clk = ~clk;

    sync_frame_rx u_dut (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .line_i(line),
        .cfg_pol_i(pol), .cfg_len_i(len), .cfg_par_i(par),
        .cfg_two_stop_i(two), .word_o(word), .valid_o(valid),
        .par_err_o(perr), .frm_err_o(ferr));

    // Capture each strobe away from the active edge.
    always @(negedge clk) begin
        if (valid) begin
            n_val++;
            l_word = word; l_perr = perr; l_ferr = ferr;
        end
        if (valid && prev_valid) n_dbl++;
        if (!valid && (perr || ferr)) n_dbl++;
        prev_valid = valid;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // One bit period: non-reading edge, line change, then the reading edge.
    task automatic send_bit(input logic b);
        sclk = ~pol;
        repeat (2) @(posedge clk);
        line = b;
        repeat (HALF - 2) @(posedge clk);
        sclk = pol;
        repeat (HALF) @(posedge clk);
    endtask

    task automatic send_frame(input logic [8:0] d, input int nb, input logic bad_par,
                              input logic bad_stop, input logic stop2);
        logic p;
        p = 1'b0;
        for (int i = 0; i < nb; i++) p ^= d[i];
        send_bit(1'b0);
        for (int i = 0; i < nb; i++) send_bit(d[i]);
        if (par[1]) send_bit((par[0] ? ~p : p) ^ bad_par);
        send_bit(~bad_stop);
        if (two) send_bit(stop2);
        line = 1'b1;
        repeat (4 * HALF) @(posedge clk);
    endtask

    task automatic expect_frame(input string req, input int base, input logic [8:0] w,
                                input logic pe, input logic fe);
        chk({req, " count"}, n_val - base, 1);
        chk({req, " word"}, l_word, w);
        chk({req, " par_err"}, l_perr, pe);
        chk({req, " frm_err"}, l_ferr, fe);
    endtask

    task automatic set_pol(input logic p);
        pol = p; sclk = p;
        repeat (4 * HALF) @(posedge clk);
    endtask

    task automatic t_reset();
        chk("R12 reset valid", valid, 0);
        chk("R12 reset flags", {perr, ferr}, 0);
    endtask

    task automatic t_idle();
        int b = n_val;
        for (int i = 0; i < 10; i++) send_bit(1'b1);
        chk("R3 idle no frame", n_val - b, 0);
    endtask

    task automatic t_pol0();
        int b = n_val;
        set_pol(1'b0); len = 3'd3; par = 2'b00;
        send_frame(9'h0A5, 8, 0, 0, 1);
        expect_frame("R1 R4 R8 pol0 8bit", b, 9'h0A5, 0, 0);
    endtask

    task automatic t_pol1_even();
        int b = n_val;
        set_pol(1'b1); len = 3'd3; par = 2'b10;
        send_frame(9'h03C, 8, 0, 0, 1);
        expect_frame("R2 R6 pol1 even", b, 9'h03C, 0, 0);
        b = n_val;
        send_frame(9'h071, 8, 1, 0, 1);
        expect_frame("R6 even error", b, 9'h071, 1, 0);
    endtask

    task automatic t_odd();
        int b = n_val;
        len = 3'd4; par = 2'b11;
        repeat (4) @(posedge clk);
        send_frame(9'h1B3, 9, 0, 0, 1);
        expect_frame("R7 R4 odd 9bit", b, 9'h1B3, 0, 0);
        b = n_val;
        send_frame(9'h155, 9, 1, 0, 1);
        expect_frame("R7 odd error", b, 9'h155, 1, 0);
    endtask

    task automatic t_short();
        int b = n_val;
        set_pol(1'b0); len = 3'd0; par = 2'b00;
        send_frame(9'h015, 5, 0, 0, 1);
        expect_frame("R5 R4 5bit", b, 9'h015, 0, 0);
        b = n_val; len = 3'd1;
        repeat (4) @(posedge clk);
        send_frame(9'h02B, 6, 0, 0, 1);
        expect_frame("R5 6bit", b, 9'h02B, 0, 0);
        b = n_val; len = 3'd7;
        repeat (4) @(posedge clk);
        send_frame(9'h181, 9, 0, 0, 1);
        expect_frame("R4 code7 9bit", b, 9'h181, 0, 0);
    endtask

    task automatic t_frame_err();
        int b = n_val;
        len = 3'd2; par = 2'b00;
        repeat (4) @(posedge clk);
        send_frame(9'h05A, 7, 0, 1, 1);
        expect_frame("R9 stop low", b, 9'h05A, 0, 1);
    endtask

    task automatic t_two_stop();
        int b = n_val;
        len = 3'd3; par = 2'b00; two = 1'b1;
        repeat (4) @(posedge clk);
        send_frame(9'h0C3, 8, 0, 0, 0);
        expect_frame("R10 second stop low", b, 9'h0C3, 0, 0);
        b = n_val;
        send_frame(9'h00F, 8, 0, 0, 1);
        expect_frame("R10 next frame", b, 9'h00F, 0, 0);
        two = 1'b0;
    endtask

    task automatic t_cfg_change();
        int b = n_val;
        len = 3'd3; par = 2'b00;
        repeat (4) @(posedge clk);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        len = 3'd0;
        for (int i = 0; i < 12; i++) send_bit(1'b1);
        chk("R11 dropped frame", n_val - b, 0);
        b = n_val;
        send_frame(9'h011, 5, 0, 0, 1);
        expect_frame("R11 recovery", b, 9'h011, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        repeat (6) @(posedge clk);
        @(negedge clk);
        t_reset();
        t_idle();
        t_pol0();
        t_pol1_even();
        t_odd();
        t_short();
        t_frame_err();
        t_two_stop();
        t_cfg_change();
        chk("R12 single-cycle strobe", n_dbl, 0);
        summary();
    end
endmodule